// File: doc/BRIEF.md
# Terminated Rate-Half Convolutional Encoder

This block turns a serial bit stream into a stream of two-bit code symbols using a convolutional code. The code has three memory stages and so eight states. Each data bit is taken through a valid/ready handshake. One registered symbol comes out for each bit on the cycle after that bit is accepted.

A flag on the final data bit of a frame starts the termination. The encoder then feeds itself three zero bits, one per cycle, and holds its input ready low until they are done. It emits one symbol for each of these tail bits. The state is then back at all zeros, so the next frame starts from a known point. A frame of N data bits therefore produces N+3 symbols, which is 2(N+3) coded bits. A one-cycle done pulse comes out together with the final tail symbol.

The generator taps and the memory depth are parameters. The defaults give the 1111/1101 generator pair. A downstream consumer takes a symbol on every cycle that its valid is high.

Top module: `conv_enc_top`

## Requirements
- R1: A synchronous active-high reset clears the three state bits to 000. While reset is held, and on the first cycle after it, sym_valid and done are 0 and in_ready is 1.
- R2: Bit 1 (the MSB) of each symbol is the XOR of the encoded bit and all three state bits.
- R3: Bit 0 (the LSB) of each symbol is the XOR of the encoded bit, the newest state bit and the oldest state bit.
- R4: When a bit is encoded, it moves into the newest state position and the oldest state bit is discarded. Encoding a 1 from state 000 therefore leads to state 100.
- R5: A data bit is accepted on a clock edge where in_valid and in_ready are both 1. Its symbol is on sym_out, with sym_valid high, for exactly the following cycle.
- R6: After a bit accepted with in_last=1, the next three cycles each emit one symbol computed with a zero input bit. in_ready stays low until the third tail symbol has been produced.
- R7: done is high for exactly one cycle, the cycle that carries the third tail symbol. The state is 000 at that point.
- R8: On a cycle with no accepted bit and no tail in progress, no symbol is emitted and the state does not change.
- R9: in_valid while in_ready is low is ignored. The offered bit stays pending and is encoded only once in_ready returns.
- R10: The frame 1011 yields the symbols 11 11 01 11 01 01 11. The frame holding a single 1 yields 11 11 10 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A data bit is offered |
| in_bit | input | 1 | Data bit value |
| in_last | input | 1 | Offered bit is the final bit of its frame |
| in_ready | output | 1 | Encoder can accept a data bit |
| sym_out | output | 2 | Code symbol, first generator in bit 1 |
| sym_valid | output | 1 | sym_out holds a new symbol |
| done | output | 1 | Final tail symbol of a frame is on sym_out |

## Verification
The encoder is driven with the 1011 frame and the lone-1 impulse, which have fixed known outputs. These two show whether the generator taps and the shift direction are right. It is also driven with all-ones and all-zeros frames: all-ones fills every state bit, and all-zeros must give zero symbols. Two mixed frames of 12 and 16 bits cover all eight states. A table of these frames is sent back to back, and some entries have idle gaps inside the frame. Back-to-back sending checks that the next frame's first bit waits through the tail, and the gaps check that idle cycles leave the state alone. A reset in the middle of a frame, followed by the impulse frame, checks that reset really returns the state to zero.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;
  localparam int MAX_WIN = 16;

  // Parity of the tapped positions of a window {current bit, state}.
  function automatic logic tap_parity(input logic [MAX_WIN-1:0] taps,
                                      input logic [MAX_WIN-1:0] window);
    return ^(taps & window);
  endfunction
endpackage

// File: rtl/conv_enc_state.sv
module conv_enc_state #(
  parameter int MEM = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           shift_en,
  input  logic           shift_in,
  output logic [MEM-1:0] state
);
  // state[MEM-1] is the newest bit, state[0] the oldest
  always_ff @(posedge clk) begin
    if (rst)           state <= '0;
    else if (shift_en) state <= {shift_in, state[MEM-1:1]};
  end

  // R4: the entering bit lands in the newest position
  p_shift_newest_r4: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> state[MEM-1] == $past(shift_in));
  // R4: the other bits move one step toward the oldest end
  p_shift_move_r4: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> state[MEM-2:0] == $past(state[MEM-1:1]));
endmodule

// File: rtl/conv_enc_tail.sv
module conv_enc_tail #(
  parameter int TAIL_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_end,
  output logic tail_active,
  output logic tail_final
);
  localparam int CW = $clog2(TAIL_LEN + 1);
  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)              remain <= '0;
    else if (frame_end)   remain <= CW'(TAIL_LEN);
    else if (remain != 0) remain <= remain - 1'b1;
  end

  assign tail_active = (remain != 0);
  assign tail_final  = (remain == CW'(1));

  // R6: the tail counter never exceeds the tail length
  p_tail_bound_r6: assert property (@(posedge clk) disable iff (rst)
    remain <= CW'(TAIL_LEN));
  // R6: a frame end starts a full tail
  p_tail_start_r6: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> tail_active);
endmodule

// File: rtl/conv_enc_symgen.sv
module conv_enc_symgen #(
  parameter int             MEM   = 3,
  parameter logic [MEM:0]   GEN_A = 4'b1111,
  parameter logic [MEM:0]   GEN_B = 4'b1101
) (
  input  logic           cur_bit,
  input  logic [MEM-1:0] state,
  output logic [1:0]     sym
);
  localparam int W   = MEM + 1;
  localparam int PAD = conv_enc_pkg::MAX_WIN - W;

  logic [conv_enc_pkg::MAX_WIN-1:0] win;
  assign win = {{PAD{1'b0}}, cur_bit, state};

  assign sym[1] = conv_enc_pkg::tap_parity({{PAD{1'b0}}, GEN_A}, win);
  assign sym[0] = conv_enc_pkg::tap_parity({{PAD{1'b0}}, GEN_B}, win);
endmodule

// File: rtl/conv_enc_top.sv
module conv_enc_top #(
  parameter int           MEM   = 3,
  parameter logic [MEM:0] GEN_A = 4'b1111,
  parameter logic [MEM:0] GEN_B = 4'b1101
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       in_bit,
  input  logic       in_last,
  output logic       in_ready,
  output logic [1:0] sym_out,
  output logic       sym_valid,
  output logic       done
);
  logic           tail_active;
  logic           tail_final;
  logic           accept;
  logic           step;
  logic           enc_bit;
  logic           frame_end;
  logic [MEM-1:0] state;
  logic [1:0]     sym_next;

  // Named internal events
  assign in_ready  = !tail_active;
  assign accept    = in_valid && in_ready;
  assign frame_end = accept && in_last;
  assign step      = accept || tail_active;
  assign enc_bit   = accept ? in_bit : 1'b0;

  conv_enc_state #(.MEM(MEM)) u_state (
    .clk(clk), .rst(rst), .shift_en(step), .shift_in(enc_bit), .state(state)
  );

  conv_enc_tail #(.TAIL_LEN(MEM)) u_tail (
    .clk(clk), .rst(rst), .frame_end(frame_end),
    .tail_active(tail_active), .tail_final(tail_final)
  );

  conv_enc_symgen #(.MEM(MEM), .GEN_A(GEN_A), .GEN_B(GEN_B)) u_symgen (
    .cur_bit(enc_bit), .state(state), .sym(sym_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_out   <= '0;
      sym_valid <= 1'b0;
      done      <= 1'b0;
    end else begin
      sym_valid <= step;
      done      <= tail_final;
      if (step) sym_out <= sym_next;
    end
  end

  // R1: after reset the encoder is idle in state zero
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (state == '0 && !sym_valid && !done && in_ready));
  // R5: an accepted bit gives a symbol on the next cycle
  p_valid_after_accept_r5: assert property (@(posedge clk) disable iff (rst)
    accept |=> sym_valid);
  // R6: input is held off right after the last data bit
  p_ready_drop_r6: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> !in_ready);
  // R6: tail steps push zeros into the state
  p_tail_zero_r6: assert property (@(posedge clk) disable iff (rst)
    tail_active |=> !state[MEM-1]);
  // R7: done comes with a flushed state and lasts one cycle
  p_done_flushed_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> state == '0);
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: an idle cycle leaves state alone and emits nothing
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && in_ready) |=> ($stable(state) && !sym_valid));
endmodule

// File: tb/conv_enc_top_tb_top.sv
module conv_enc_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic [1:0] sym_out;
  logic       sym_valid;
  logic       done;

  always #4 clk = ~clk;

  conv_enc_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .in_last(in_last), .in_ready(in_ready), .sym_out(sym_out),
    .sym_valid(sym_valid), .done(done)
  );

  int nvec = 0;
  int nbad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  logic [1:0] exp_sym  [0:511];
  logic       exp_done [0:511];
  logic [1:0] got_log  [0:511];
  int wr = 0;
  int rd = 0;
  logic [3:0] past_in = '0;   // past_in[0] = one bit ago, [2] = three bits ago

  // Stimulus table: frame bits sent MSB first, length, idle gap after bit 1
  localparam int NV = 6;
  localparam logic [15:0] VBITS [0:NV-1] =
    '{16'h000B, 16'h0001, 16'h0000, 16'h00FF, 16'h096C, 16'hA5C3};
  localparam int VLEN [0:NV-1] = '{4, 1, 1, 8, 12, 16};
  localparam int VGAP [0:NV-1] = '{0, 0, 0, 2, 0, 3};

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Bench model: sum of input taps over the last four encoded bits
  task automatic model_push(input logic b, input logic is_done);
    logic m1, m0;
    m1 = b ^ past_in[0] ^ past_in[1] ^ past_in[2];   // R2
    m0 = b ^ past_in[0] ^ past_in[2];                // R3
    exp_sym[wr]  = {m1, m0};
    exp_done[wr] = is_done;
    wr++;
    past_in = {past_in[2:0], b};                     // R4
  endtask

  task automatic send_bit(input logic b, input logic last);
    @(negedge clk);
    in_valid = 1'b1; in_bit = b; in_last = last;
    while (!in_ready) @(negedge clk);   // R9: held until ready returns
    model_push(b, 1'b0);
    if (last) begin
      model_push(1'b0, 1'b0);
      model_push(1'b0, 1'b0);
      model_push(1'b0, 1'b1);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [15:0] bits, input int len, input int gap);
    for (int i = len - 1; i >= 0; i--) begin
      send_bit(bits[i], i == 0);
      if (gap > 0 && i == len - 1 && len > 1) idle(gap);   // R8
    end
  endtask

  // Output monitor: R2, R3, R5, R6, R7
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (sym_valid) begin
        if (rd >= wr) chk(1'b0, "R5 spurious symbol", 1, 0);
        else begin
          chk(sym_out == exp_sym[rd], "R2/R3 symbol", sym_out, exp_sym[rd]);
          chk(done == exp_done[rd], "R7 done", done, exp_done[rd]);
          got_log[rd] = sym_out;
          rd++;
        end
      end else if (done) chk(1'b0, "R7 done without symbol", 1, 0);
    end
  end

  task automatic check_log(input int base, input int n, input logic [15:0] expbits,
                           input string req);
    logic [15:0] got = '0;
    for (int i = 0; i < n; i++) got = {got[13:0], got_log[base + i]};
    chk(got == expbits, req, got, expbits);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog", cycles, 20000);
      summary();
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1: outputs while reset is held
    chk(sym_valid == 0 && done == 0 && in_ready == 1, "R1 reset held", {sym_valid, done, in_ready}, 3'b001);
    rst = 1'b0;
    @(negedge clk);
    chk(sym_valid == 0 && done == 0 && in_ready == 1, "R1 after reset", {sym_valid, done, in_ready}, 3'b001);

    // Table walk, frames back to back (R9 at each frame start)
    for (int v = 0; v < NV; v++) begin
      base = wr;
      send_frame(VBITS[v], VLEN[v], VGAP[v]);
      if (v == 0) begin
        idle(6);
        check_log(base, 7, 16'b11110111010111, "R10 frame 1011");
      end
      if (v == 1) begin
        idle(6);
        check_log(base, 4, 16'b11111011, "R10 impulse");
      end
    end
    idle(6);
    chk(rd == wr, "R6 symbol count", rd, wr);

    // R6: ready timing around the tail
    send_bit(1'b1, 1'b1);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(in_ready == 0, "R6 ready low during tail", in_ready, 0);
      @(negedge clk);
    end
    chk(in_ready == 1 && done == 1, "R6/R7 ready back with done", {in_ready, done}, 2'b11);
    @(negedge clk);
    chk(done == 0 && sym_valid == 0, "R7 done single cycle / R8 idle", {done, sym_valid}, 2'b00);

    // R8: long idle gap inside a frame, then compare via monitor
    send_bit(1'b1, 1'b0);
    idle(5);
    chk(sym_valid == 0, "R8 no symbol when idle", sym_valid, 0);
    send_bit(1'b0, 1'b0);
    send_bit(1'b1, 1'b1);
    idle(6);
    chk(rd == wr, "R8 count after gap", rd, wr);

    // R1: reset mid-frame, then impulse must match from state 000
    send_bit(1'b1, 1'b0);
    send_bit(1'b1, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd = wr;
    past_in = '0;
    @(negedge clk);
    chk(sym_valid == 0 && in_ready == 1, "R1 mid-frame reset", {sym_valid, in_ready}, 2'b01);
    base = wr;
    send_bit(1'b1, 1'b1);
    idle(6);
    check_log(base, 4, 16'b11111011, "R1/R4 impulse after reset");
    chk(rd == wr, "R10 final count", rd, wr);

    finished = 1'b1;
    summary();
  end
endmodule